// File: doc/BRIEF.md
# Lockdown-Aware Replacement Way Picker

This block decides which way of an eight-way set-associative cache receives a new line when an allocating miss occurs. Each request names the master that caused the miss. The requester also supplies the valid bits of the addressed set. The picker compares these against a lockdown mask held for that master and returns the chosen way in two forms: a one-hot vector and a binary index. If the master has locked every way, the picker instead raises a flag that forbids allocation.

Software, or a surrounding controller, loads one lockdown mask per master through a small write port. A mode input travels with each request and selects the policy at run time. The pseudo-random policy starts from a free-running shift register. The deterministic policy walks a round-robin pointer. Under either policy, an empty way that is not locked is filled before any valid line is displaced.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, `vic_valid`, `no_alloc`, `vic_onehot` and `vic_idx` are all zero. Every lockdown mask is cleared, and the round-robin pointer is at way 0.
- R2: A cycle with `cfg_we` high stores `cfg_mask` as the lockdown mask of master `cfg_id`. Bit i set to 1 locks way i. The new mask applies to requests presented from the following cycle onward.
- R3: A request (`req_valid` high) is answered exactly one cycle later: exactly one of `vic_valid` and `no_alloc` is high for that single cycle. In a cycle after one with no request, both are low.
- R4: The picker never chooses a way that is locked in the mask of the requesting master.
- R5: When the set contains an invalid way that is unlocked (`set_valid` bit 0), the picker chooses the lowest-numbered such way, whatever the mode.
- R6: When every way is locked for the requester, `no_alloc` is high, `vic_valid` is low and `vic_onehot` is zero.
- R7: With `mode_det` high and no unlocked invalid way, the victim is the first unlocked way at or above the pointer, wrapping from way 7 to way 0. The pointer then moves to the way after the victim. No other response moves the pointer.
- R8: With `mode_det` low and no unlocked invalid way, a 16-bit shift register that advances every cycle supplies a start way. The victim is the first unlocked way at or above that start, wrapping. Over many requests, every unlocked way is chosen.
- R9: When `vic_valid` is high, `vic_onehot` has exactly one bit set, and that bit's position equals `vic_idx`.
- R10: The mode may change between any two requests. Pseudo-random picks leave the round-robin pointer where the last deterministic pick put it.
- R11: Writing the mask of one master leaves the masks of all other masters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Lockdown mask write strobe |
| cfg_id | input | 2 | Master whose mask is written |
| cfg_mask | input | 8 | Mask value, 1 = way locked |
| req_valid | input | 1 | Allocation request strobe |
| req_id | input | 2 | Requesting master |
| mode_det | input | 1 | 1 = round-robin, 0 = pseudo-random |
| set_valid | input | 8 | Valid bit of each way in the addressed set |
| vic_valid | output | 1 | Victim way reported |
| vic_onehot | output | 8 | Victim way, one-hot |
| vic_idx | output | 3 | Victim way, binary |
| no_alloc | output | 1 | All ways locked for the requester |

## Verification
The bench builds the picker with its default parameters: eight ways, four masters and a 16-bit shift register. With only eight ways, a fully locked mask, a mask with a single unlocked way, and a pointer wrapping past way 7 all arise within a few hundred random requests. The four masters make it possible to check mask isolation against every other master. Coverage of unlocked ways under the pseudo-random policy is reached within a few hundred requests, because only the low three bits of the shift register select the start way.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    // Which rule produced the registered answer.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_EMPTY   = 2'd1,
        SRC_ROBIN   = 2'd2,
        SRC_RANDOM  = 2'd3
    } pick_src_e;

    // Next position on a ring of n slots.
    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/vsel_mask_bank.sv
module vsel_mask_bank #(
    parameter int WAYS    = 8,
    parameter int MASTERS = 4,
    parameter int ID_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic [WAYS-1:0] wr_mask,
    input  logic [ID_W-1:0] rd_id,
    output logic [WAYS-1:0] rd_mask
);
    logic [WAYS-1:0] bank [MASTERS];

    for (genvar m = 0; m < MASTERS; m++) begin : g_master
        logic [WAYS-1:0] mask_d, mask_q;

        always_comb begin
            mask_d = mask_q;
            if (wr_en && (wr_id == ID_W'(m))) begin
                mask_d = wr_mask;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else begin
                mask_q <= mask_d;
            end
        end

        assign bank[m] = mask_q;
    end

    always_comb begin
        rd_mask = '0;
        if (int'(rd_id) < MASTERS) begin
            rd_mask = bank[rd_id];
        end
    end
endmodule

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic [W-1:0] sr_d, sr_q;
    logic         fb;

    always_comb begin
        fb   = ^(sr_q & TAPS);
        sr_d = {sr_q[W-2:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign state = sr_q;
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
    parameter int WAYS  = 8,
    parameter int IDX_W = 3
) (
    input  logic [WAYS-1:0]  cand,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // First candidate at or above start, wrapping round the ring.
    always_comb begin
        int pos;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WAYS; i++) begin
            pos = (int'(start) + i) % WAYS;
            if (!found && cand[pos]) begin
                found = 1'b1;
                idx   = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
    parameter int WAYS    = 8,
    parameter int MASTERS = 4,
    parameter int ID_W    = 2,
    parameter int RND_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [ID_W-1:0] cfg_id,
    input  logic [WAYS-1:0] cfg_mask,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            mode_det,
    input  logic [WAYS-1:0] set_valid,
    output logic            vic_valid,
    output logic [WAYS-1:0] vic_onehot,
    output logic [$clog2(WAYS)-1:0] vic_idx,
    output logic            no_alloc
);
    import vsel_pkg::*;

    localparam int IDX_W  = $clog2(WAYS);
    localparam int N_PICK = 3;   // 0: empty way, 1: round-robin, 2: random
    localparam int P_EMPTY = 0;
    localparam int P_ROBIN = 1;
    localparam int P_RAND  = 2;

    typedef struct packed {
        logic             vic_valid;
        logic             no_alloc;
        logic [WAYS-1:0]  onehot;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] ptr;
        pick_src_e        src;
    } sel_state_t;

    sel_state_t s_d, s_q;

    logic [WAYS-1:0]  lock_mask;
    logic [WAYS-1:0]  free_ways;
    logic [RND_W-1:0] rnd;
    logic [IDX_W-1:0] rnd_start;

    logic [WAYS-1:0]  p_cand  [N_PICK];
    logic [IDX_W-1:0] p_start [N_PICK];
    logic             p_found [N_PICK];
    logic [IDX_W-1:0] p_idx   [N_PICK];

    vsel_mask_bank #(
        .WAYS    (WAYS),
        .MASTERS (MASTERS),
        .ID_W    (ID_W)
    ) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_id   (cfg_id),
        .wr_mask (cfg_mask),
        .rd_id   (req_id),
        .rd_mask (lock_mask)
    );

    vsel_lfsr #(
        .W (RND_W)
    ) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    assign free_ways = ~lock_mask;
    assign rnd_start = IDX_W'(32'(rnd[IDX_W-1:0]) % WAYS);

    assign p_cand[P_EMPTY]  = free_ways & ~set_valid;
    assign p_start[P_EMPTY] = '0;
    assign p_cand[P_ROBIN]  = free_ways;
    assign p_start[P_ROBIN] = s_q.ptr;
    assign p_cand[P_RAND]   = free_ways;
    assign p_start[P_RAND]  = rnd_start;

    for (genvar g = 0; g < N_PICK; g++) begin : g_pick
        vsel_pick #(
            .WAYS  (WAYS),
            .IDX_W (IDX_W)
        ) u_pick (
            .cand  (p_cand[g]),
            .start (p_start[g]),
            .found (p_found[g]),
            .idx   (p_idx[g])
        );
    end

    always_comb begin
        s_d           = s_q;
        s_d.vic_valid = 1'b0;
        s_d.no_alloc  = 1'b0;
        s_d.onehot    = '0;
        s_d.idx       = '0;
        s_d.src       = SRC_NONE;
        if (req_valid) begin
            if (free_ways == '0) begin
                s_d.no_alloc = 1'b1;
            end else if (p_found[P_EMPTY]) begin
                s_d.vic_valid = 1'b1;
                s_d.idx       = p_idx[P_EMPTY];
                s_d.src       = SRC_EMPTY;
            end else if (mode_det) begin
                s_d.vic_valid = 1'b1;
                s_d.idx       = p_idx[P_ROBIN];
                s_d.ptr       = IDX_W'(ring_next(32'(p_idx[P_ROBIN]), WAYS));
                s_d.src       = SRC_ROBIN;
            end else begin
                s_d.vic_valid = 1'b1;
                s_d.idx       = p_idx[P_RAND];
                s_d.src       = SRC_RANDOM;
            end
            if (s_d.vic_valid) begin
                s_d.onehot = WAYS'(1) << s_d.idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{vic_valid: 1'b0, no_alloc: 1'b0, onehot: '0,
                     idx: '0, ptr: '0, src: SRC_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign vic_valid  = s_q.vic_valid;
    assign no_alloc   = s_q.no_alloc;
    assign vic_onehot = s_q.onehot;
    assign vic_idx    = s_q.idx;
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
    parameter int WAYS  = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [WAYS-1:0]  lock_mask,
    input logic [WAYS-1:0]  set_valid,
    input logic             vic_valid,
    input logic             no_alloc,
    input logic [WAYS-1:0]  vic_onehot,
    input logic [IDX_W-1:0] vic_idx
);
    // R3: a request gets exactly one kind of answer next cycle
    a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (vic_valid != no_alloc));

    // R3: no request, no answer
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!vic_valid && !no_alloc));

    // R4: the victim is never locked for the requester
    a_r4_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((vic_onehot & $past(lock_mask)) == '0));

    // R5: an unlocked empty way is preferred
    a_r5_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((~set_valid & ~lock_mask) != '0))
        |=> ((vic_onehot & ~$past(set_valid)) != '0));

    // R6: a no-allocate answer carries no way
    a_r6_no_way: assert property (@(posedge clk) disable iff (!rst_n)
        no_alloc |-> (vic_onehot == '0));

    // R9: one-hot and binary forms agree
    a_r9_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> ($countones(vic_onehot) == 1 && vic_onehot[vic_idx]));

    a_r9_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vic_onehot));
endmodule

bind way_victim_sel vsel_checker #(
    .WAYS  (WAYS),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .lock_mask  (lock_mask),
    .set_valid  (set_valid),
    .vic_valid  (vic_valid),
    .no_alloc   (no_alloc),
    .vic_onehot (vic_onehot),
    .vic_idx    (vic_idx)
);

// File: tb/sim_way_victim_sel.sv
`timescale 1ns/1ps
module sim_way_victim_sel;
    localparam int WAYS = 8;
    localparam int ID_W = 2;
    localparam int MST  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [ID_W-1:0] cfg_id = '0;
    logic [WAYS-1:0] cfg_mask = '0;
    logic            req_valid = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic            mode_det = 1'b1;
    logic [WAYS-1:0] set_valid = '1;
    logic            vic_valid;
    logic [WAYS-1:0] vic_onehot;
    logic [2:0]      vic_idx;
    logic            no_alloc;

    int total = 0;
    int bad = 0;
    logic [WAYS-1:0] m_mask [MST];
    int m_ptr = 0;
    logic [WAYS-1:0] seen;

    always #10 clk = ~clk;

    way_victim_sel u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_mask(cfg_mask), .req_valid(req_valid), .req_id(req_id),
        .mode_det(mode_det), .set_valid(set_valid), .vic_valid(vic_valid),
        .vic_onehot(vic_onehot), .vic_idx(vic_idx), .no_alloc(no_alloc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int first_from(input logic [WAYS-1:0] c, input int s);
        for (int i = 0; i < WAYS; i++) begin
            if (c[(s + i) % WAYS]) return (s + i) % WAYS;
        end
        return -1;
    endfunction

    task automatic write_mask(input int id, input logic [WAYS-1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = ID_W'(id); cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
        m_mask[id] = m;
    endtask

    // One request, answer checked half a cycle after the registering edge.
    task automatic request(input int id, input bit det, input logic [WAYS-1:0] sv);
        logic [WAYS-1:0] lk, empt;
        int exp;
        @(negedge clk);
        req_valid = 1'b1; req_id = ID_W'(id); mode_det = det; set_valid = sv;
        @(negedge clk);
        req_valid = 1'b0;
        lk = m_mask[id];
        empt = ~lk & ~sv;
        check(vic_valid != no_alloc, "R3 single answer", {vic_valid, no_alloc}, 2);
        if (lk == '1) begin
            check(no_alloc && vic_onehot == '0, "R6 all locked", int'(vic_onehot), 0);
        end else begin
            check(vic_valid && vic_onehot == (WAYS'(1) << vic_idx),
                  "R9 index form", int'(vic_onehot), int'(WAYS'(1) << vic_idx));
            check((vic_onehot & lk) == '0, "R4 locked way", int'(vic_onehot), int'(lk));
            if (empt != '0) begin
                exp = first_from(empt, 0);
                check(int'(vic_idx) == exp, "R5 empty way first", vic_idx, exp);
            end else if (det) begin
                exp = first_from(~lk, m_ptr);
                check(int'(vic_idx) == exp, "R7 round robin", vic_idx, exp);
                m_ptr = (exp + 1) % WAYS;
            end else begin
                seen = seen | vic_onehot;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < MST; i++) m_mask[i] = '0;
        seen = '0;
        void'($urandom(32'd1234));
        #35;
        check(!vic_valid && !no_alloc && vic_onehot == '0 && vic_idx == '0,
              "R1 reset outputs", {vic_valid, no_alloc}, 0);
        rst_n = 1'b1;

        // R1 R7: pointer starts at 0 and walks with no locks
        for (int k = 0; k < 10; k++) request(0, 1'b1, '1);

        // R3: idle cycle gives no answer
        @(negedge clk);
        check(!vic_valid && !no_alloc, "R3 idle", {vic_valid, no_alloc}, 0);

        // R2 R11: mask for master 1 only
        write_mask(1, 8'b0000_0111);
        request(1, 1'b1, '1);
        request(0, 1'b1, '1);
        request(1, 1'b1, '1);

        // R6: fully locked master
        write_mask(2, 8'hFF);
        request(2, 1'b1, '1);
        request(2, 1'b0, 8'h00);

        // R5: empty ways, both modes
        request(0, 1'b1, 8'b1110_1011);
        request(1, 1'b0, 8'b1110_0110);
        request(1, 1'b1, 8'b0000_0101);

        // R7: single unlocked way
        write_mask(3, 8'b1111_1101);
        request(3, 1'b1, '1);
        request(3, 1'b1, '1);

        // R8: coverage of unlocked ways in random mode
        write_mask(3, 8'b0100_1001);
        seen = '0;
        for (int k = 0; k < 300; k++) request(3, 1'b0, '1);
        check(seen == 8'b1011_0110, "R8 random coverage", seen, 8'b1011_0110);

        // R10: mode mixing with pointer preserved
        request(0, 1'b1, '1);
        for (int k = 0; k < 5; k++) request(0, 1'b0, '1);
        request(0, 1'b1, '1);

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic [WAYS-1:0] sv;
            if ($urandom_range(0, 9) == 0)
                write_mask($urandom_range(0, MST-1), WAYS'($urandom_range(0, 255)));
            sv = ($urandom_range(0, 3) == 0) ? WAYS'($urandom_range(0, 255)) : '1;
            request($urandom_range(0, MST-1), 1'($urandom_range(0, 1)), sv);
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk);
                check(!vic_valid && !no_alloc, "R3 gap", {vic_valid, no_alloc}, 0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule